// File: doc/BRIEF.md
# Six-Channel Programmable Interval Timer

This block holds six independent down-counting timers behind a small word-addressed register bus, and it runs entirely on one system clock. Four clock-enable pulse inputs act as the time bases. For each channel, software picks one of these four inputs and a divider that is a power of two. It then loads an interval and starts the channel in one of two modes: periodic, which reloads the counter and keeps running, or one-shot, which stops the channel after a single expiry. Every expiry latches a bit in a shared status register. Each channel drives its own interrupt line, which is the AND of that status bit and the matching bit of a shared enable mask. Software clears a status bit by writing a 1 to it.

Each channel is controlled by a two-state machine with states `CH_STOP` and `CH_RUN`. It has four named transitions:
- START (`CH_STOP` to `CH_RUN`): a control write with the enable bit set.
- HALT (`CH_RUN` to `CH_STOP`): a control write with the enable bit clear.
- FINISH (`CH_RUN` to `CH_STOP`): an expiry while one-shot mode is selected.
- WRAP (`CH_RUN` to `CH_RUN`): a periodic expiry that reloads the counter.

A prescaler beside each channel counts pulses of the selected source. It issues one count tick each time 2^div pulses have arrived.

Top module: `pit_top`

## Requirements
- R1: Reset leaves the block in this state:
  - every channel is stopped;
  - every control register reads 0x04 (source 1, divide by 1, periodic, disabled);
  - every interval and count register reads 0;
  - the interrupt enable and status registers read 0;
  - all irq lines are low.
- R2: Register map:
  - 0x00 is the interrupt enable register and 0x04 is the status register, each using bits [5:0].
  - Channel i (0..5) occupies the 16-byte slot at 0x10*(i+1): control at +0, interval at +4, live count at +8.
- R3: The control fields set the time base:
  - Control bits [3:2] select which of the four src_tick inputs drives the channel.
  - Bits [6:4] hold an exponent d, so the running channel gets one count tick per 2^d pulses of that input.
  - The pulse count restarts from zero on every control write.
- R4: On each tick a running channel decrements its counter. A tick that arrives while the counter is 0 or 1 is an expiry. In periodic mode an expiry reloads the counter from the interval, so an interval of N≥1 expires every N ticks, and an interval of 0 expires on every tick.
- R5: Control bit 7 selects one-shot mode. On expiry in this mode the counter goes to 0, the channel stops, and the enable bit (control bit 0) reads back as 0.
- R6: Writing control with bit 0 clear stops the channel. A stopped channel holds its count unchanged.
- R7: A control write with bit 1 set loads the counter from the interval register. Bit 1 always reads back as 0.
- R8: An interval write stores the value and also loads it into the counter.
- R9: Status bits:
  - An expiry sets status bit i.
  - Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
  - An expiry in the same cycle as a clear of that bit leaves the bit set.
- R10: irq[i] is high exactly when status bit i and enable bit i are both 1, and it follows writes to either register in the next cycle.
- R11: Several accesses have no effect:
  - Writes to a count register are ignored.
  - Reads of unmapped offsets (for example 0x08, 0x0C, 0x1C, 0x80) return 0.
  - Writes to unmapped offsets change no register.
- R12: A write to a channel's control or interval register discards that channel's tick in the same cycle, so the count does not also step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 4 | Clock-enable pulses of the four time bases |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 6 | Level interrupt per channel |

## Verification
The checker watches several behaviours on every clock:
- a status bit falls only under a write that clears it;
- an expiry is always followed by its status bit;
- expiries occur only on running channels;
- a one-shot expiry takes the channel out of `CH_RUN`;
- a stopped channel's count does not move while the bus is idle;
- a zero enable mask silences every line.

Only the bench scenarios can show the exact tick rate for each source and divider, the reload and interval-load values, the readback of control fields, and the dropped tick when a write collides with a tick. The same holds for ignored count and unmapped writes. The bench's cycle-level model covers all of these in every cycle.

// File: rtl/pit_pkg.sv
package pit_pkg;

    // control word field positions
    localparam int CTL_EN      = 0;
    localparam int CTL_RLD     = 1;
    localparam int CTL_SEL_LSB = 2;
    localparam int CTL_SEL_W   = 2;
    localparam int CTL_DIV_LSB = 4;
    localparam int CTL_DIV_W   = 3;
    localparam int CTL_ONE     = 7;

    // register window layout
    localparam int OFF_IEN     = 'h00;
    localparam int OFF_IST     = 'h04;
    localparam int SLOT_STRIDE = 'h10;
    localparam int OFF_CTL     = 'h0;
    localparam int OFF_IVL     = 'h4;
    localparam int OFF_CNT     = 'h8;

    typedef enum logic {
        CH_STOP = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pit_prescale.sv
module pit_prescale
    import pit_pkg::*;
#(
    parameter int SEL_W = CTL_SEL_W,
    parameter int DIV_W = CTL_DIV_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [(1<<SEL_W)-1:0]   src_tick,
    input  logic [SEL_W-1:0]        sel,
    input  logic [DIV_W-1:0]        div,
    input  logic                    run,
    input  logic                    restart,
    output logic                    tick
);
    localparam int PC_W = (1 << DIV_W) - 1;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] limit;
    logic            pulse;
    logic            last;

    always_comb begin
        limit = PC_W'((1 << div) - 1);
        pulse = src_tick[sel];
        last  = (pc_q == limit);
        tick  = run & pulse & last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (restart || !run) begin
            pc_q <= '0;
        end else if (pulse) begin
            pc_q <= last ? '0 : pc_q + 1'b1;
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int                   DW      = 32,
    parameter logic [CTL_SEL_W-1:0] DEF_SRC = 2'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [(1<<CTL_SEL_W)-1:0]   src_tick,
    input  logic                        wr_ctl,
    input  logic                        wr_ivl,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               ctl_rd,
    output logic [DW-1:0]               ivl_rd,
    output logic [DW-1:0]               cnt_rd,
    output logic                        expire,
    output logic                        running,
    output logic                        oneshot
);
    ch_state_e              st_q, st_d;
    logic [CTL_SEL_W-1:0]   sel_q;
    logic [CTL_DIV_W-1:0]   div_q;
    logic                   one_q;
    logic [DW-1:0]          ivl_q;
    logic [DW-1:0]          cnt_q;
    logic                   tick_raw;
    logic                   tick;

    pit_prescale #(
        .SEL_W (CTL_SEL_W),
        .DIV_W (CTL_DIV_W)
    ) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_tick (src_tick),
        .sel      (sel_q),
        .div      (div_q),
        .run      (st_q == CH_RUN),
        .restart  (wr_ctl),
        .tick     (tick_raw)
    );

    // a register write on this channel wins over its tick
    assign tick   = tick_raw & ~wr_ctl & ~wr_ivl;
    assign expire = tick & (cnt_q <= DW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_STOP;
        else        st_q <= st_d;
    end

    // transitions: START, HALT, FINISH, WRAP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_STOP: begin
                if (wr_ctl && wdata[CTL_EN]) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (wr_ctl)                 st_d = wdata[CTL_EN] ? CH_RUN : CH_STOP;
                else if (expire && one_q)   st_d = CH_STOP;
                else                        st_d = CH_RUN;
            end
            default: st_d = CH_STOP;
        endcase
    end

    // configuration fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= DEF_SRC;
            div_q <= '0;
            one_q <= 1'b0;
        end else if (wr_ctl) begin
            sel_q <= wdata[CTL_SEL_LSB +: CTL_SEL_W];
            div_q <= wdata[CTL_DIV_LSB +: CTL_DIV_W];
            one_q <= wdata[CTL_ONE];
        end
    end

    // interval and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ivl_q <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_ivl) ivl_q <= wdata;
            if (wr_ivl) begin
                cnt_q <= wdata;
            end else if (wr_ctl && wdata[CTL_RLD]) begin
                cnt_q <= ivl_q;
            end else if (tick) begin
                if (expire) cnt_q <= one_q ? '0 : ivl_q;
                else        cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ctl_rd                             = '0;
        ctl_rd[CTL_EN]                     = (st_q == CH_RUN);
        ctl_rd[CTL_SEL_LSB +: CTL_SEL_W]   = sel_q;
        ctl_rd[CTL_DIV_LSB +: CTL_DIV_W]   = div_q;
        ctl_rd[CTL_ONE]                    = one_q;
        ivl_rd                             = ivl_q;
        cnt_rd                             = cnt_q;
        running                            = (st_q == CH_RUN);
        oneshot                            = one_q;
    end

endmodule

// File: rtl/pit_irq.sv
module pit_irq #(
    parameter int NCH = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ien,
    input  logic            wr_ist,
    input  logic [NCH-1:0]  wdata,
    input  logic [NCH-1:0]  set,
    output logic [NCH-1:0]  ien_q,
    output logic [NCH-1:0]  ist_q,
    output logic [NCH-1:0]  irq
);
    logic [NCH-1:0] clr;

    assign clr = wr_ist ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ien_q <= '0;
            ist_q <= '0;
        end else begin
            if (wr_ien) ien_q <= wdata;
            ist_q <= (ist_q & ~clr) | set;
        end
    end

    assign irq = ist_q & ien_q;

endmodule

// File: rtl/pit_top.sv
module pit_top
    import pit_pkg::*;
#(
    parameter int                   NCH     = 6,
    parameter int                   DW      = 32,
    parameter int                   ADDR_W  = 8,
    parameter logic [CTL_SEL_W-1:0] DEF_SRC = 2'd1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [(1<<CTL_SEL_W)-1:0]   src_tick,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_we,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    output logic [NCH-1:0]              irq
);
    logic                       wr_ien, wr_ist;
    logic [NCH-1:0]             wr_ctl, wr_ivl;
    logic [NCH-1:0]             exp_v, run_v, mode_v;
    logic [NCH-1:0][DW-1:0]     ctl_rd, ivl_rd, cnt_rd;
    logic [NCH-1:0]             ien_q, ist_q;

    assign wr_ien = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
    assign wr_ist = bus_we && (bus_addr == ADDR_W'(OFF_IST));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int BASE = SLOT_STRIDE * (g + 1);

        assign wr_ctl[g] = bus_we && (bus_addr == ADDR_W'(BASE + OFF_CTL));
        assign wr_ivl[g] = bus_we && (bus_addr == ADDR_W'(BASE + OFF_IVL));

        pit_channel #(
            .DW      (DW),
            .DEF_SRC (DEF_SRC)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_tick (src_tick),
            .wr_ctl   (wr_ctl[g]),
            .wr_ivl   (wr_ivl[g]),
            .wdata    (bus_wdata),
            .ctl_rd   (ctl_rd[g]),
            .ivl_rd   (ivl_rd[g]),
            .cnt_rd   (cnt_rd[g]),
            .expire   (exp_v[g]),
            .running  (run_v[g]),
            .oneshot  (mode_v[g])
        );
    end

    pit_irq #(
        .NCH (NCH)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ien (wr_ien),
        .wr_ist (wr_ist),
        .wdata  (bus_wdata[NCH-1:0]),
        .set    (exp_v),
        .ien_q  (ien_q),
        .ist_q  (ist_q),
        .irq    (irq)
    );

    // read mux: unmapped offsets return zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_IEN)) bus_rdata = DW'(ien_q);
        if (bus_addr == ADDR_W'(OFF_IST)) bus_rdata = DW'(ist_q);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(SLOT_STRIDE * (i + 1) + OFF_CTL)) bus_rdata = ctl_rd[i];
            if (bus_addr == ADDR_W'(SLOT_STRIDE * (i + 1) + OFF_IVL)) bus_rdata = ivl_rd[i];
            if (bus_addr == ADDR_W'(SLOT_STRIDE * (i + 1) + OFF_CNT)) bus_rdata = cnt_rd[i];
        end
    end

endmodule

// File: rtl/pit_chk.sv
module pit_chk
    import pit_pkg::*;
#(
    parameter int NCH    = 6,
    parameter int DW     = 32,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    input  logic [NCH-1:0]          irq,
    input  logic [NCH-1:0]          ien,
    input  logic [NCH-1:0]          ist,
    input  logic [NCH-1:0]          run,
    input  logic [NCH-1:0]          expire,
    input  logic [NCH-1:0]          oneshot,
    input  logic [NCH-1:0][DW-1:0]  cnt
);
    logic           wr_ien_c, wr_ist_c;
    logic [NCH-1:0] clr_mask;

    assign wr_ien_c = bus_we && (bus_addr == ADDR_W'(OFF_IEN));
    assign wr_ist_c = bus_we && (bus_addr == ADDR_W'(OFF_IST));
    assign clr_mask = wr_ist_c ? bus_wdata[NCH-1:0] : '0;

    // R9
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(ist) & ~ist) & ~$past(clr_mask)) == '0));

    // R10
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ien_c && (bus_wdata[NCH-1:0] == '0)) |=> (irq == '0));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R9
        expire_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> ist[g]);

        // R4
        expire_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |-> run[g]);

        // R5
        oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire[g] && oneshot[g]) |=> !run[g]);

        // R6
        hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !bus_we) |=> $stable(cnt[g]));
    end

endmodule

bind pit_top pit_chk #(
    .NCH    (NCH),
    .DW     (DW),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ien       (ien_q),
    .ist       (ist_q),
    .run       (run_v),
    .expire    (exp_v),
    .oneshot   (mode_v),
    .cnt       (cnt_rd)
);

// File: tb/tb_pit_top.sv
`timescale 1ns/1ps
module tb_pit_top;
    localparam int NCH = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick = 4'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [5:0]  irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int scyc = 0;
    bit done = 0;
    string cur_req = "R1";

    pit_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    always #10 clk = ~clk;

    // time bases: every cycle, every 2nd, every 3rd, every 5th
    always @(negedge clk) begin
        src_tick[0] = 1'b1;
        src_tick[1] = (scyc % 2) == 0;
        src_tick[2] = (scyc % 3) == 0;
        src_tick[3] = (scyc % 5) == 0;
        scyc++;
    end

    // ---------------- behavioural reference model ----------------
    int unsigned m_sel[NCH], m_div[NCH], m_one[NCH], m_en[NCH];
    int unsigned m_ivl[NCH], m_cnt[NCH], m_pc[NCH];
    int unsigned m_ien, m_ist;

    function automatic int unsigned m_read(int unsigned a);
        if (a == 0) return m_ien;
        if (a == 4) return m_ist;
        for (int i = 0; i < NCH; i++) begin
            int unsigned b = 16 * (i + 1);
            if (a == b)     return (m_one[i] << 7) | (m_div[i] << 4) | (m_sel[i] << 2) | m_en[i];
            if (a == b + 4) return m_ivl[i];
            if (a == b + 8) return m_cnt[i];
        end
        return 0;
    endfunction

    task automatic m_step();
        int unsigned a, d, set, clr;
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_sel[i] = 1; m_div[i] = 0; m_one[i] = 0; m_en[i] = 0;
                m_ivl[i] = 0; m_cnt[i] = 0; m_pc[i] = 0;
            end
            m_ien = 0; m_ist = 0;
            return;
        end
        a = bus_addr; d = bus_wdata; set = 0; clr = 0;
        for (int i = 0; i < NCH; i++) begin
            bit wc, wi, tk;
            wc = bus_we && (a == 16 * (i + 1));
            wi = bus_we && (a == 16 * (i + 1) + 4);
            tk = 0;
            if (m_en[i] && src_tick[m_sel[i]]) begin
                if (m_pc[i] == (1 << m_div[i]) - 1) begin tk = 1; m_pc[i] = 0; end
                else m_pc[i]++;
            end
            if (wc || wi) tk = 0;
            if (tk) begin
                if (m_cnt[i] <= 1) begin
                    set |= (1 << i);
                    if (m_one[i] != 0) begin m_en[i] = 0; m_cnt[i] = 0; m_pc[i] = 0; end
                    else m_cnt[i] = m_ivl[i];
                end else begin
                    m_cnt[i]--;
                end
            end
            if (wc) begin
                m_en[i] = d & 1; m_sel[i] = (d >> 2) & 3; m_div[i] = (d >> 4) & 7;
                m_one[i] = (d >> 7) & 1; m_pc[i] = 0;
                if ((d & 2) != 0) m_cnt[i] = m_ivl[i];
            end
            if (wi) begin m_ivl[i] = d; m_cnt[i] = d; end
        end
        if (bus_we && a == 0) m_ien = d & 'h3F;
        if (bus_we && a == 4) clr = d & 'h3F;
        m_ist = (m_ist & ~clr) | set;
    endtask

    always @(posedge clk) begin
        m_step();
        #5;
        total++;
        if (irq !== 6'(m_ien & m_ist)) begin
            bad++;
            $display("FAIL %s cycle irq: got %h expected %h", cur_req, irq, 6'(m_ien & m_ist));
        end
        total++;
        if (bus_rdata !== m_read(bus_addr)) begin
            bad++;
            $display("FAIL %s cycle read @%h: got %h expected %h", cur_req, bus_addr, bus_rdata, m_read(bus_addr));
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
            finish_run();
        end
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [31:0] a0;
        idle(5);
        rst_n = 1'b1;
        idle(1);

        cur_req = "R1";
        rd(8'h10, 32'h4, "R1 ctrl0 reset");
        rd(8'h60, 32'h4, "R1 ctrl5 reset");
        rd(8'h00, 32'h0, "R1 ien reset");
        rd(8'h04, 32'h0, "R1 ist reset");
        rd(8'h18, 32'h0, "R1 count0 reset");
        chk("R1 irq reset", 32'(irq), 32'h0);

        cur_req = "R8";
        wr(8'h14, 32'd5);
        rd(8'h14, 32'd5, "R2 R8 interval0");
        rd(8'h18, 32'd5, "R8 count0 loaded");

        cur_req = "R4";
        wr(8'h10, 32'h01);
        idle(12);
        rd(8'h04, 32'h1, "R4 R9 status0 set");
        chk("R10 irq masked", 32'(irq), 32'h0);

        cur_req = "R10";
        wr(8'h00, 32'h3F);
        #1 chk("R10 irq0 up", 32'(irq), 32'h1);
        cur_req = "R9";
        wr(8'h04, 32'h0);
        rd(8'h04, 32'h1, "R9 write zero keeps");
        wr(8'h10, 32'h00);
        wr(8'h04, 32'h01);
        rd(8'h04, 32'h0, "R9 w1c");
        chk("R10 irq down", 32'(irq), 32'h0);

        cur_req = "R6";
        bus_addr = 8'h18; #1 a0 = bus_rdata;
        idle(10);
        rd(8'h18, a0, "R6 stopped holds");

        cur_req = "R7";
        wr(8'h10, 32'h02);
        rd(8'h18, 32'd5, "R7 reload");
        rd(8'h10, 32'h0, "R7 reload bit reads 0");

        cur_req = "R5";
        wr(8'h24, 32'd3);
        wr(8'h20, 32'hA5);
        idle(80);
        rd(8'h20, 32'hA4, "R5 enable cleared");
        rd(8'h28, 32'h0, "R5 count zero");
        rd(8'h04, 32'h2, "R5 R9 status1");
        chk("R10 irq1", 32'(irq), 32'h2);
        wr(8'h04, 32'h2);

        cur_req = "R11";
        wr(8'h28, 32'h1234);
        rd(8'h28, 32'h0, "R11 count write ignored");
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R11 unmapped 0C");
        rd(8'h2C, 32'h0, "R11 unmapped 2C");
        rd(8'h80, 32'h0, "R11 unmapped 80");
        rd(8'h00, 32'h3F, "R11 ien intact");
        rd(8'h24, 32'd3, "R11 interval1 intact");

        cur_req = "R4";
        wr(8'h34, 32'd0);
        wr(8'h30, 32'h01);
        idle(3);
        rd(8'h04, 32'h4, "R4 interval zero expires");
        wr(8'h30, 32'h00);
        wr(8'h04, 32'h4);

        cur_req = "R3";
        wr(8'h44, 32'd50);
        wr(8'h40, 32'h1D);
        idle(3);
        bus_addr = 8'h48; #1 a0 = bus_rdata;
        idle(40);
        rd(8'h48, a0 - 32'd4, "R3 src3 div2 rate");

        cur_req = "R12";
        wr(8'h14, 32'd100);
        wr(8'h10, 32'h01);
        idle(5);
        bus_addr = 8'h18; #1 a0 = bus_rdata;
        wr(8'h10, 32'h01);
        rd(8'h18, a0, "R12 tick dropped on write");
        idle(1);
        rd(8'h18, a0 - 32'd1, "R4 next tick counts");

        cur_req = "R3";
        wr(8'h64, 32'd2);
        wr(8'h60, 32'h71);
        wr(8'h54, 32'd7);
        wr(8'h50, 32'h39);
        wr(8'h34, 32'd9);
        wr(8'h30, 32'h95);
        for (int k = 0; k < 6; k++) begin
            bus_addr = 8'(16 * (k + 1) + 8);
            idle(250);
            if (k == 2) wr(8'h00, 32'h2A);
            wr(8'h04, 32'h3F);
        end

        finish_run();
    end

endmodule